// File: doc/BRIEF.md
# Timestamped Input Event Capture Unit

This block watches four digital input lines and records when something happens on them. A 16-bit time base runs freely, advancing once every eight clock cycles. Each line has its own edge qualifier. When a qualifying edge arrives, the unit stores a record that holds the current time-base value and a 4-bit mask naming every line that qualified in that cycle.

Records enter a small FIFO. The oldest record moves automatically into a holding register. Software removes a record in two steps: it reads the status word, which carries the mask and a valid bit, and then it reads the time word. Only that second read lets the next record advance.

The unit raises interrupt requests in four cases: when a record loads into the holding register, at two FIFO fill thresholds, when the time base wraps, and on rising edges of line 0. It also reports the current synchronized pin levels.

All access goes through a small register bus. Read data is registered, one cycle after the read strobe. Register addresses are 0 (config), 1 (status), 2 (time), 3 (flags) and 4 (live time base).

Top module: `evcap_top`

## Requirements
- R1: The time base clears to 0 on reset and increments by one on every eighth rising clock edge. The live time-base register (address 4) reads it back.
- R2: Each line has an edge-mode field in config bits [2i+1:2i]. The encodings are: 0 captures rising edges, 1 captures falling edges, 2 captures both edges, and 3 captures every eighth rising edge.
- R3: Config bits [8+i] enable line i, and all lines are disabled after reset. A disabled line never produces a record, and its eighth-edge counter is held at zero, so counting restarts from zero after the line is enabled again.
- R4: A record's status bits [3:0] flag every line that qualified in the same cycle, and those lines share one record. Its time field equals the time-base value after the second rising clock edge that follows the pin change.
- R5: Status (address 1) shows the held mask in bits [3:0] and the holding-valid bit in bit 4, and reading it has no side effect. A time read (address 2) releases the holding register only if a status read came after the last load. Otherwise it returns the time and leaves the record in place.
- R6: The FIFO (7 records) and the holding register together keep at most 8 records. An event that arrives when the FIFO is full is dropped and sets the sticky drop flag (flags bit 3, `drop_flag`), which is cleared by writing 1 to it.
- R7: Each load into the holding register sets the sticky load flag (flags bit 0, `irq_load`), which is cleared by writing 1 to it.
- R8: `irq_fill_lo` is high while the FIFO alone holds 4 or more records, and `irq_fill_hi` is high while it holds 6 or more records. The holding register is not counted.
- R9: Status bits [11:8] show the four pin levels after a two-flop synchronizer, whatever the enables and modes are.
- R10: A rising edge on line 0 sets the sticky flag in flags bit 5 (`irq_line0`) even when line 0 is disabled. Writing 1 to that bit clears it.
- R11: When the time base wraps from all-ones to zero, the sticky flag in flags bit 4 (`irq_wrap`) is set on that same clock edge. Writing 1 to that bit clears it.
- R12: After reset, `bus_rdata`, every flag and interrupt output, and the holding-valid bit are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 4 | Asynchronous event inputs |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the strobe |
| irq_load | output | 1 | Sticky holding-register load flag |
| irq_fill_lo | output | 1 | FIFO holds 4 or more records |
| irq_fill_hi | output | 1 | FIFO holds 6 or more records |
| irq_line0 | output | 1 | Sticky line-0 rising-edge flag |
| irq_wrap | output | 1 | Sticky time-base wrap flag |
| drop_flag | output | 1 | Sticky dropped-event flag |

## Verification
The bench drives lines set to opposite edge modes and checks that only the configured edge leaves a record. A wrong edge decoder would leave records on the ignored edge or lose them on the captured one. Two lines changing in the same cycle must produce one record with two mask bits; a design that serialises them would produce two records. Two more cases cover the counting rules. Eighth-edge mode must fire on exactly the eighth rise, and disabling the line in the middle of a count must restart the count. A counter that keeps its value would fire three rises early. The bench also checks the pop rule. A time read without a prior status read must leave the record in place. A design that pops on every time read would lose that record, and the next status read would report it invalid. The bench also fills the unit to eight records and sends a ninth event. This checks that the extra event is dropped and flagged, that the earlier eight drain intact and in order, and that the fill levels leave the holding register out of their count.

// File: rtl/evcap_pkg.sv
package evcap_pkg;
  typedef enum logic [1:0] {
    EM_RISE = 2'd0,
    EM_FALL = 2'd1,
    EM_BOTH = 2'd2,
    EM_DIV8 = 2'd3
  } edge_mode_e;

  localparam logic [2:0] A_CFG   = 3'd0;
  localparam logic [2:0] A_STAT  = 3'd1;
  localparam logic [2:0] A_TIME  = 3'd2;
  localparam logic [2:0] A_FLAG  = 3'd3;
  localparam logic [2:0] A_TBASE = 3'd4;

  localparam int FB_LOAD  = 0;
  localparam int FB_LO    = 1;
  localparam int FB_HI    = 2;
  localparam int FB_DROP  = 3;
  localparam int FB_WRAP  = 4;
  localparam int FB_LINE0 = 5;
endpackage

// File: rtl/evcap_timebase.sv
module evcap_timebase #(
  parameter int TB_W    = 16,
  parameter int PRESC_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TB_W-1:0] tb_o,
  output logic            wrap_o
);
  logic [PRESC_W-1:0] presc_q;
  logic [TB_W-1:0]    tb_q;
  logic               tick;

  assign tick = (presc_q == {PRESC_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      tb_q    <= '0;
    end else begin
      presc_q <= presc_q + 1'b1;
      if (tick) tb_q <= tb_q + 1'b1;
    end
  end

  assign tb_o   = tb_q;
  assign wrap_o = tick && (tb_q == {TB_W{1'b1}});

  // R1: the count only moves on a prescaler tick
  p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> tb_q == $past(tb_q));
  // R11: a wrap indication is followed by a zero count
  p_wrap_to_zero_r11: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> tb_q == '0);
endmodule

// File: rtl/evcap_line.sv
module evcap_line
  import evcap_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic       en_i,
  input  edge_mode_e mode_i,
  output logic       hit_o,
  output logic       lvl_o
);
  logic             s1, s2, s3;
  logic [DIV_W-1:0] div_q;
  logic             rise, fall;

  assign rise  = s2 & ~s3;
  assign fall  = ~s2 & s3;
  assign lvl_o = s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      s3    <= 1'b0;
      div_q <= '0;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
      s3 <= s2;
      if (!en_i || mode_i != EM_DIV8) div_q <= '0;
      else if (rise)                  div_q <= div_q + 1'b1;
    end
  end

  always_comb begin
    hit_o = 1'b0;
    if (en_i) begin
      case (mode_i)
        EM_RISE: hit_o = rise;
        EM_FALL: hit_o = fall;
        EM_BOTH: hit_o = rise | fall;
        EM_DIV8: hit_o = rise && (div_q == {DIV_W{1'b1}});
        default: hit_o = 1'b0;
      endcase
    end
  end

  // R3: a disabled line keeps its edge counter at zero
  p_div_cleared_r3: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> div_q == '0);
endmodule

// File: rtl/evcap_fifo.sv
module evcap_fifo #(
  parameter int DW    = 20,
  parameter int DEPTH = 7,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (push_i) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o  = mem[rp_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));

  // R6: occupancy moves by at most one record per cycle and never exceeds depth
  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1));
  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/evcap_top.sv
module evcap_top
  import evcap_pkg::*;
#(
  parameter int NLINES     = 4,
  parameter int TB_W       = 16,
  parameter int PRESC_W    = 3,
  parameter int DIV_W      = 3,
  parameter int FIFO_DEPTH = 7,
  parameter int FILL_LO    = 4,
  parameter int FILL_HI    = 6,
  parameter int BUS_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       pins_i,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq_load,
  output logic             irq_fill_lo,
  output logic             irq_fill_hi,
  output logic             irq_line0,
  output logic             irq_wrap,
  output logic             drop_flag
);
  localparam int REC_W = NLINES + TB_W;
  localparam int FCW   = $clog2(FIFO_DEPTH + 1);

  logic [2*NLINES-1:0] mode_q;
  logic [NLINES-1:0]   en_q;
  logic [NLINES-1:0]   hits, live;
  logic                any_hit;
  logic [TB_W-1:0]     tb;
  logic                wrap;

  evcap_timebase #(.TB_W(TB_W), .PRESC_W(PRESC_W)) u_tb (
    .clk(clk), .rst(rst), .tb_o(tb), .wrap_o(wrap));

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    evcap_line #(.DIV_W(DIV_W)) u_line (
      .clk(clk), .rst(rst), .pin_i(pins_i[i]), .en_i(en_q[i]),
      .mode_i(edge_mode_e'(mode_q[2*i +: 2])),
      .hit_o(hits[i]), .lvl_o(live[i]));
  end

  assign any_hit = |hits;

  // storage: FIFO feeding one holding register
  logic             f_push, f_pop, f_full, drop_evt;
  logic [REC_W-1:0] f_dout;
  logic [FCW-1:0]   f_cnt;
  logic [REC_W-1:0] hold_q;
  logic             hold_v, armed;
  logic             stat_rd, time_rd, pop_ok, cfg_wr, flag_wr;

  assign f_push   = any_hit & ~f_full;
  assign drop_evt = any_hit & f_full;
  assign f_pop    = ~hold_v & (f_cnt != '0);

  evcap_fifo #(.DW(REC_W), .DEPTH(FIFO_DEPTH), .CW(FCW)) u_fifo (
    .clk(clk), .rst(rst), .push_i(f_push), .din_i({hits, tb}),
    .pop_i(f_pop), .dout_o(f_dout), .count_o(f_cnt), .full_o(f_full));

  assign stat_rd = bus_rd && (bus_addr == A_STAT);
  assign time_rd = bus_rd && (bus_addr == A_TIME);
  assign pop_ok  = time_rd && hold_v && armed;
  assign cfg_wr  = bus_wr && (bus_addr == A_CFG);
  assign flag_wr = bus_wr && (bus_addr == A_FLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      hold_v <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (f_pop) begin
        hold_q <= f_dout;
        hold_v <= 1'b1;
        armed  <= 1'b0;
      end else if (pop_ok) begin
        hold_v <= 1'b0;
        armed  <= 1'b0;
      end else if (stat_rd && hold_v) begin
        armed  <= 1'b1;
      end
    end
  end

  // configuration
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      en_q   <= '0;
    end else if (cfg_wr) begin
      mode_q <= bus_wdata[2*NLINES-1:0];
      en_q   <= bus_wdata[8 +: NLINES];
    end
  end

  // flags and interrupt requests
  logic       live0_q, rise0;
  logic [5:0] clr;
  logic       fl_load, fl_drop, fl_wrap, fl_line0, lvl_lo, lvl_hi;

  assign rise0 = live[0] & ~live0_q;
  assign clr   = flag_wr ? bus_wdata[5:0] : 6'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      live0_q  <= 1'b0;
      fl_load  <= 1'b0;
      fl_drop  <= 1'b0;
      fl_wrap  <= 1'b0;
      fl_line0 <= 1'b0;
      lvl_lo   <= 1'b0;
      lvl_hi   <= 1'b0;
    end else begin
      live0_q  <= live[0];
      fl_load  <= (fl_load  & ~clr[FB_LOAD])  | f_pop;
      fl_drop  <= (fl_drop  & ~clr[FB_DROP])  | drop_evt;
      fl_wrap  <= (fl_wrap  & ~clr[FB_WRAP])  | wrap;
      fl_line0 <= (fl_line0 & ~clr[FB_LINE0]) | rise0;
      lvl_lo   <= (f_cnt >= FCW'(FILL_LO));
      lvl_hi   <= (f_cnt >= FCW'(FILL_HI));
    end
  end

  assign irq_load    = fl_load;
  assign irq_fill_lo = lvl_lo;
  assign irq_fill_hi = lvl_hi;
  assign irq_line0   = fl_line0;
  assign irq_wrap    = fl_wrap;
  assign drop_flag   = fl_drop;

  // register read path
  logic [BUS_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (bus_addr)
      A_CFG: begin
        rd_val[2*NLINES-1:0] = mode_q;
        rd_val[8 +: NLINES]  = en_q;
      end
      A_STAT: begin
        rd_val[NLINES-1:0]  = hold_q[REC_W-1 -: NLINES];
        rd_val[4]           = hold_v;
        rd_val[8 +: NLINES] = live;
      end
      A_TIME:  rd_val[TB_W-1:0] = hold_q[TB_W-1:0];
      A_FLAG: begin
        rd_val[FB_LOAD]  = fl_load;
        rd_val[FB_LO]    = lvl_lo;
        rd_val[FB_HI]    = lvl_hi;
        rd_val[FB_DROP]  = fl_drop;
        rd_val[FB_WRAP]  = fl_wrap;
        rd_val[FB_LINE0] = fl_line0;
      end
      A_TBASE: rd_val[TB_W-1:0] = tb;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // R5: the holding register empties only through an armed time read
  p_pop_needs_arm_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_v) |-> $past(time_rd && armed));
  // R7: every load into the holding register raises the load flag
  p_load_flag_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_v) |-> irq_load);
  // R6: the drop flag stays set until software clears it
  p_drop_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (drop_flag && !(flag_wr && bus_wdata[FB_DROP])) |=> drop_flag);
  // R8: the upper threshold implies the lower one
  p_fill_order_r8: assert property (@(posedge clk) disable iff (rst)
    irq_fill_hi |-> irq_fill_lo);
endmodule

// File: tb/tb_evcap_top.sv
module tb_evcap_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  pins;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_load, irq_fill_lo, irq_fill_hi, irq_line0, irq_wrap, drop_flag;
  logic [15:0] w_rdata;
  logic        w_load, w_lo, w_hi, w_line0, w_wrap, w_drop;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  logic [19:0] expq[$];

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  evcap_top dut (
    .clk(clk), .rst(rst), .pins_i(pins), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_load(irq_load), .irq_fill_lo(irq_fill_lo), .irq_fill_hi(irq_fill_hi),
    .irq_line0(irq_line0), .irq_wrap(irq_wrap), .drop_flag(drop_flag));

  evcap_top #(.TB_W(8)) dut_wrap (
    .clk(clk), .rst(rst), .pins_i(4'd0), .bus_addr(3'd0), .bus_wr(1'b0),
    .bus_rd(1'b0), .bus_wdata(16'd0), .bus_rdata(w_rdata),
    .irq_load(w_load), .irq_fill_lo(w_lo), .irq_fill_hi(w_hi),
    .irq_line0(w_line0), .irq_wrap(w_wrap), .drop_flag(w_drop));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: change pins and, if a record is due, queue its expected content
  task automatic set_pins(input logic [3:0] v, input bit expect_rec, input logic [3:0] m);
    @(negedge clk);
    if (expect_rec) expq.push_back({m, 16'((cyc + 2) >> 3)});
    pins = v;
    repeat (4) @(negedge clk);
  endtask

  // monitor: remove n records through the two-step read and compare
  task automatic drain(input int n, input string req);
    logic [15:0] st, tm;
    logic [19:0] e;
    for (int k = 0; k < n; k++) begin
      bus_read(3'd1, st);
      chk({req, " R5 holding valid"}, 32'(st[4]), 32'd1);
      bus_read(3'd2, tm);
      if (expq.size() == 0) begin
        chk({req, " R4 unexpected record"}, 32'(st[3:0]), 32'hF0);
      end else begin
        e = expq.pop_front();
        chk({req, " R4 mask"}, 32'(st[3:0]), 32'(e[19:16]));
        chk({req, " R4 time"}, 32'(tm), 32'(e[15:0]));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst = 1'b1; pins = 4'd0; bus_addr = 3'd0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = 16'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk("R12 rdata", 32'(bus_rdata), 32'd0);
    chk("R12 irqs", 32'({irq_load, irq_fill_lo, irq_fill_hi, irq_line0, irq_wrap, drop_flag}), 32'd0);
    bus_read(3'd1, d);
    chk("R12 holding valid", 32'(d[4]), 32'd0);
    bus_read(3'd3, d);
    chk("R12 flags", 32'(d[5:0]), 32'd0);

    // R1 time base: read the live count and compare with the cycle count
    @(negedge clk);
    bus_addr = 3'd4; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R1 time base", 32'(bus_rdata), 32'((cyc - 1) >> 3));

    // R11 wrap of the 8-bit instance at edge 2048
    while (cyc != 2047) @(negedge clk);
    chk("R11 before wrap", 32'(w_wrap), 32'd0);
    @(negedge clk);
    chk("R11 at wrap", 32'(w_wrap), 32'd1);

    // R10 and R3: line 0 disabled still flags its rising edge, no record
    set_pins(4'b0001, 0, 4'd0);
    chk("R10 line0 flag", 32'(irq_line0), 32'd1);
    bus_read(3'd1, d);
    chk("R3 disabled no record", 32'(d[4]), 32'd0);
    bus_write(3'd3, 16'h0020);
    chk("R10 line0 clear", 32'(irq_line0), 32'd0);
    set_pins(4'b0000, 0, 4'd0);

    // R2 modes: line0 rise, line1 fall, line2 both, line3 every eighth rise
    bus_write(3'd0, 16'h0FE4);
    set_pins(4'b0001, 1, 4'b0001);
    set_pins(4'b0000, 0, 4'd0);
    set_pins(4'b0010, 0, 4'd0);
    set_pins(4'b0000, 1, 4'b0010);
    set_pins(4'b0100, 1, 4'b0100);
    set_pins(4'b0000, 1, 4'b0100);
    set_pins(4'b0101, 1, 4'b0101);   // R4 merged record
    set_pins(4'b0000, 1, 4'b0100);
    chk("R8 fill lo at 5", 32'(irq_fill_lo), 32'd1);
    chk("R8 fill hi at 5", 32'(irq_fill_hi), 32'd0);
    chk("R7 load flag", 32'(irq_load), 32'd1);
    set_pins(4'b0010, 0, 4'd0);
    set_pins(4'b0000, 1, 4'b0010);
    chk("R8 fill hi at 6", 32'(irq_fill_hi), 32'd1);
    set_pins(4'b1000, 0, 4'd0);      // line3 rise 1 of 8
    bus_read(3'd1, d);
    chk("R9 live pins", 32'(d[11:8]), 32'b1000);
    drain(7, "R2");
    bus_read(3'd1, d);
    chk("R5 empty after drain", 32'(d[4]), 32'd0);
    chk("R8 fill lo after drain", 32'(irq_fill_lo), 32'd0);

    // R5 time read before status read must not pop
    set_pins(4'b1001, 1, 4'b0001);
    bus_read(3'd2, d);
    chk("R5 unarmed time value", 32'(d), 32'(expq[0][15:0]));
    bus_read(3'd1, d);
    chk("R5 unarmed read kept record", 32'(d[4]), 32'd1);
    drain(1, "R5");
    bus_write(3'd3, 16'h0001);
    chk("R7 load flag clear", 32'(irq_load), 32'd0);

    // R2 eighth-rise mode: rises 2..8 on line3
    for (int r = 2; r <= 8; r++) begin
      set_pins(4'b0001, 0, 4'd0);
      set_pins(4'b1001, r == 8, 4'b1000);
    end
    drain(1, "R2 div8");

    // R3 disabling resets the counter
    for (int r = 0; r < 3; r++) begin
      set_pins(4'b0001, 0, 4'd0);
      set_pins(4'b1001, 0, 4'd0);
    end
    bus_write(3'd0, 16'h07E4);
    bus_write(3'd0, 16'h0FE4);
    for (int r = 0; r < 5; r++) begin
      set_pins(4'b0001, 0, 4'd0);
      set_pins(4'b1001, 0, 4'd0);
    end
    bus_read(3'd1, d);
    chk("R3 counter restarted", 32'(d[4]), 32'd0);
    for (int r = 5; r < 8; r++) begin
      set_pins(4'b0001, 0, 4'd0);
      set_pins(4'b1001, r == 7, 4'b1000);
    end
    drain(1, "R3");

    // R6 capacity: nine events, the ninth is dropped
    for (int k = 0; k < 9; k++) begin
      set_pins((k % 2 == 0) ? 4'b1101 : 4'b1001, k < 8, 4'b0100);
    end
    chk("R6 drop flag", 32'(drop_flag), 32'd1);
    bus_read(3'd3, d);
    chk("R6 drop flag bit", 32'(d[3]), 32'd1);
    drain(8, "R6");
    bus_read(3'd1, d);
    chk("R6 only eight kept", 32'(d[4]), 32'd0);
    bus_write(3'd3, 16'h0008);
    chk("R6 drop clear", 32'(drop_flag), 32'd0);
    chk("R6 queue empty", 32'(expq.size()), 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule